// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind a bus controller that has already turned SDA/SCL activity into whole received bytes. It looks at the byte or bytes that open each transaction and decides whether this device is being addressed. In 7-bit mode the upper seven bits of the first byte are compared with the programmed address. In 10-bit mode a reserved header byte carrying the `11110` prefix and the two top address bits is followed by a second byte holding the low eight bits. Only when both bytes agree is the device selected.

Two reserved first-byte values are reported on their own flags in either mode. A first byte of `0x00` is the general call and `0x01` is the START byte. The direction bit of every first byte is captured. Once raised, a selection stays up as a level until a STOP arrives or another first byte is evaluated. After a full 10-bit selection, a repeated start followed by a read header (R/W = 1) re-selects the device without a second byte.

The controller is one state machine with these states:
- `ST_IDLE`: waiting for an address.
- `ST_HDR_OK`: a 10-bit header matched and the low byte is awaited.
- `ST_SELECTED`: the unique address matched.
- `ST_GCALL`: a general call was seen.
- `ST_SBYTE`: a START byte was seen.
- `ST_UNSEL`: the address was not for this device.

Its transitions are:
- STOP: from any state to `ST_IDLE`.
- First-byte evaluation: from any state to `ST_GCALL`, `ST_SBYTE`, `ST_SELECTED` (7-bit hit, or 10-bit re-select), `ST_HDR_OK` (10-bit header) or `ST_UNSEL`.
- Low-byte compare: from `ST_HDR_OK` to `ST_SELECTED` on a match, or to `ST_UNSEL` on a mismatch.

Top module: `i2c_addr_match`

## Requirements
- R1: In 7-bit mode (`ten_bit_mode`=0), a first byte `b` with `b[7:1]` equal to `own_addr[6:0]`, other than 0x00 and 0x01, raises `addr_hit` in the cycle after the byte's valid cycle.
- R2: In 10-bit mode, a first byte carrying prefix `11110` in bits 7:3 and `own_addr[9:8]` in bits 2:1 does not by itself raise `addr_hit`. No other first byte except 0x00 and 0x01 raises any flag.
- R3: In 10-bit mode, a second byte (`rx_first`=0) equal to `own_addr[7:0]` that directly follows a matching header raises `addr_hit` one cycle later. Any other second byte leaves `addr_hit` low.
- R4: A first byte of 0x00 raises `gcall_hit` and leaves `addr_hit` and `sbyte_hit` low, in both modes.
- R5: A first byte of 0x01 raises `sbyte_hit` and leaves `addr_hit` and `gcall_hit` low, in both modes.
- R6: Outputs hold their values on cycles without a byte, and also across a lone `rep_start` pulse.
- R7: A second byte received while no header is pending is ignored: a 7-bit selection stays up.
- R8: A `stop_seen` pulse clears all flags and `rw_dir` one cycle later. It wins over a byte presented in the same cycle.
- R9: `rw_dir` takes bit 0 of every first byte one cycle after its valid cycle.
- R10: After a full 10-bit selection, `rep_start` followed by a header with R/W=1 raises `addr_hit` without a second byte. After a STOP, the same header does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte | input | 8 | Received byte from the bus controller |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` is valid |
| rx_first | input | 1 | 1 = first byte after START/restart, 0 = later byte |
| own_addr | input | 10 | Programmed slave address (7-bit mode uses bits 6:0) |
| ten_bit_mode | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| rep_start | input | 1 | One-cycle pulse: repeated start seen |
| stop_seen | input | 1 | One-cycle pulse: STOP seen |
| addr_hit | output | 1 | Unique address selected (level) |
| gcall_hit | output | 1 | General call received (level) |
| sbyte_hit | output | 1 | START byte received (level) |
| rw_dir | output | 1 | Direction bit of the last first byte |

## Verification
Every result is due exactly one clock after the cycle in which its `rx_valid` or `stop_seen` was high, because the state and direction registers are the only stage. The bench drives each stimulus on a falling edge and drops it on the next falling edge. It then samples the outputs on that same falling edge, half a period after the edge that registered the result. For the hold checks, idle cycles and a lone `rep_start` are inserted before sampling again, so any stray change would be seen.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_OK,
        ST_SELECTED,
        ST_GCALL,
        ST_SBYTE,
        ST_UNSEL
    } am_state_e;

    typedef enum logic [2:0] {
        FB_GCALL,
        FB_SBYTE,
        FB_HIT7,
        FB_HDR,
        FB_HDR_RESEL,
        FB_MISS
    } fb_class_e;

    localparam logic [4:0] HDR_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c_am_first_dec.sv
module i2c_am_first_dec
    import i2c_am_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              ten_bit_i,
    input  logic              resel_ok_i,
    output fb_class_e         class_o
);
    localparam int HI_W = ADDR_W - BYTE_W;
    localparam int PFX_W = BYTE_W - HI_W - 1;

    logic hdr_hit;
    logic seven_hit;

    always_comb begin
        hdr_hit   = (byte_i[BYTE_W-1 -: PFX_W] == HDR_PREFIX[PFX_W-1:0])
                 && (byte_i[HI_W:1] == own_addr_i[ADDR_W-1 -: HI_W]);
        seven_hit = (byte_i[BYTE_W-1:1] == own_addr_i[BYTE_W-2:0]);
    end

    always_comb begin
        if (byte_i == BYTE_W'(0))
            class_o = FB_GCALL;
        else if (byte_i == BYTE_W'(1))
            class_o = FB_SBYTE;
        else if (!ten_bit_i)
            class_o = seven_hit ? FB_HIT7 : FB_MISS;
        else if (hdr_hit)
            class_o = (byte_i[0] && resel_ok_i) ? FB_HDR_RESEL : FB_HDR;
        else
            class_o = FB_MISS;
    end
endmodule

// File: rtl/i2c_am_low_cmp.sv
module i2c_am_low_cmp #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              hit_o
);
    always_comb hit_o = (byte_i == own_addr_i[BYTE_W-1:0]);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit_mode,
    input  logic              rep_start,
    input  logic              stop_seen,
    output logic              addr_hit,
    output logic              gcall_hit,
    output logic              sbyte_hit,
    output logic              rw_dir
);
    am_state_e state, nxt;
    fb_class_e fb_class;
    logic      low_hit;
    logic      ten_done;
    logic      rs_pend;
    logic      first_evt;
    logic      second_evt;

    always_comb begin
        first_evt  = rx_valid && rx_first && !stop_seen;
        second_evt = rx_valid && !rx_first && !stop_seen;
    end

    i2c_am_first_dec #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) first_dec_i (
        .byte_i     (rx_byte),
        .own_addr_i (own_addr),
        .ten_bit_i  (ten_bit_mode),
        .resel_ok_i (ten_done && rs_pend),
        .class_o    (fb_class)
    );

    i2c_am_low_cmp #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) low_cmp_i (
        .byte_i     (rx_byte),
        .own_addr_i (own_addr),
        .hit_o      (low_hit)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_seen) begin
            nxt = ST_IDLE;
        end else if (first_evt) begin
            unique case (fb_class)
                FB_GCALL:     nxt = ST_GCALL;
                FB_SBYTE:     nxt = ST_SBYTE;
                FB_HIT7:      nxt = ST_SELECTED;
                FB_HDR_RESEL: nxt = ST_SELECTED;
                FB_HDR:       nxt = ST_HDR_OK;
                default:      nxt = ST_UNSEL;
            endcase
        end else if (second_evt) begin
            unique case (state)
                ST_HDR_OK: nxt = low_hit ? ST_SELECTED : ST_UNSEL;
                default:   nxt = state;
            endcase
        end
    end

    // state register and sequencing flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ten_done <= 1'b0;
            rs_pend  <= 1'b0;
            rw_dir   <= 1'b0;
        end else begin
            state <= nxt;
            if (stop_seen) begin
                ten_done <= 1'b0;
                rs_pend  <= 1'b0;
                rw_dir   <= 1'b0;
            end else begin
                if (first_evt) begin
                    rs_pend <= 1'b0;
                    rw_dir  <= rx_byte[0];
                end else if (rep_start) begin
                    rs_pend <= 1'b1;
                end
                if (second_evt && state == ST_HDR_OK && low_hit)
                    ten_done <= 1'b1;
            end
        end
    end

    // output decode
    always_comb begin
        addr_hit  = 1'b0;
        gcall_hit = 1'b0;
        sbyte_hit = 1'b0;
        unique case (state)
            ST_SELECTED: addr_hit  = 1'b1;
            ST_GCALL:    gcall_hit = 1'b1;
            ST_SBYTE:    sbyte_hit = 1'b1;
            default:     ;
        endcase
    end

    a_r1_seven_bit_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (first_evt && !ten_bit_mode && rx_byte[BYTE_W-1:1] != '0
         && rx_byte[BYTE_W-1:1] == own_addr[BYTE_W-2:0]) |=> addr_hit);

    a_r4_gcall_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (first_evt && rx_byte == '0) |=> (gcall_hit && !addr_hit && !sbyte_hit));

    a_r6_hold_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !stop_seen) |=> ($stable(addr_hit) && $stable(gcall_hit) && $stable(sbyte_hit)));

    a_r6_rise_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_hit) |-> $past(rx_valid));

    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> (!addr_hit && !gcall_hit && !sbyte_hit && !rw_dir));

    a_r9_dir_capture: assert property (@(posedge clk) disable iff (!rst_n)
        first_evt |=> (rw_dir == $past(rx_byte[0])));
endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_valid = 1'b0;
    logic       rx_first = 1'b0;
    logic [9:0] own_addr = '0;
    logic       ten_bit_mode = 1'b0;
    logic       rep_start = 1'b0;
    logic       stop_seen = 1'b0;
    logic       addr_hit, gcall_hit, sbyte_hit, rw_dir;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_addr_match dut_i (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_first(rx_first), .own_addr(own_addr), .ten_bit_mode(ten_bit_mode),
        .rep_start(rep_start), .stop_seen(stop_seen), .addr_hit(addr_hit),
        .gcall_hit(gcall_hit), .sbyte_hit(sbyte_hit), .rw_dir(rw_dir)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // packed as {addr_hit, gcall_hit, sbyte_hit, rw_dir}
    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {addr_hit, gcall_hit, sbyte_hit, rw_dir};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (addr/gcall/sbyte/rw)", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic first);
        @(negedge clk);
        rx_byte = b; rx_first = first; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
    endtask

    task automatic do_rs();
        @(negedge clk); rep_start = 1'b1;
        @(negedge clk); rep_start = 1'b0;
    endtask

    function automatic logic [3:0] exp_first(input logic ten, input logic [9:0] own,
                                              input logic [7:0] b, input logic resel);
        if (b == 8'h00) return 4'b0100;
        if (b == 8'h01) return 4'b0011;
        if (!ten) return {b[7:1] == own[6:0], 2'b00, b[0]};
        if (b[7:3] == 5'b11110 && b[2:1] == own[9:8]) return {resel && b[0], 2'b00, b[0]};
        return {3'b000, b[0]};
    endfunction

    function automatic logic [7:0] hdr(input logic [9:0] own, input logic rw);
        return {5'b11110, own[9:8], rw};
    endfunction

    initial begin
        logic [6:0] own7 [4];
        logic [9:0] own10 [3];
        own7[0] = 7'h50; own7[1] = 7'h7F; own7[2] = 7'h00; own7[3] = 7'h2B;
        own10[0] = 10'h2A5; own10[1] = 10'h0FF; own10[2] = 10'h300;

        repeat (3) @(negedge clk);
        chk("R8 reset state", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 after reset", 4'b0000);

        // R1/R4/R5/R9: 7-bit sweep of every first byte
        ten_bit_mode = 1'b0;
        for (int k = 0; k < 4; k++) begin
            own_addr = {3'b101, own7[k]};
            for (int b = 0; b < 256; b++) begin
                do_stop();
                send(8'(b), 1'b1);
                chk("R1/R4/R5/R9 7-bit first byte", exp_first(1'b0, own_addr, 8'(b), 1'b0));
            end
        end

        // R7: second byte ignored while 7-bit selected; R6 hold
        own_addr = 10'h050;
        do_stop();
        send(8'hA1, 1'b1);
        chk("R1 7-bit select", 4'b1001);
        send(8'h00, 1'b0);
        chk("R7 stray second byte ignored", 4'b1001);
        repeat (5) @(negedge clk);
        chk("R6 hold over idle", 4'b1001);
        do_rs();
        chk("R6 hold over lone rep_start", 4'b1001);
        send(8'h33, 1'b1);
        chk("R1 new first byte mismatch deselects", 4'b0001);

        // R8: stop wins over simultaneous byte
        @(negedge clk);
        rx_byte = 8'hA0; rx_first = 1'b1; rx_valid = 1'b1; stop_seen = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; stop_seen = 1'b0;
        chk("R8 stop beats byte", 4'b0000);

        // 10-bit
        ten_bit_mode = 1'b1;
        for (int k = 0; k < 3; k++) begin
            own_addr = own10[k];
            for (int b = 0; b < 256; b++) begin
                do_stop();
                send(8'(b), 1'b1);
                chk("R2/R4/R5/R9 10-bit first byte", exp_first(1'b1, own_addr, 8'(b), 1'b0));
            end
            for (int s = 0; s < 256; s++) begin
                do_stop();
                send(hdr(own_addr, 1'b0), 1'b1);
                send(8'(s), 1'b0);
                chk("R3 10-bit second byte", {8'(s) == own_addr[7:0], 3'b000});
            end
            // R10 re-select after full match
            do_stop();
            send(hdr(own_addr, 1'b0), 1'b1);
            send(own_addr[7:0], 1'b0);
            chk("R3 full 10-bit select", 4'b1000);
            do_rs();
            chk("R6 hold across rep_start", 4'b1000);
            send(hdr(own_addr, 1'b1), 1'b1);
            chk("R10 re-select read header", 4'b1001);
            // R10 negative: after stop the read header alone does not select
            do_stop();
            chk("R8 stop clears 10-bit select", 4'b0000);
            do_rs();
            send(hdr(own_addr, 1'b1), 1'b1);
            chk("R10 no re-select after stop", 4'b0001);
            // partial match cleared by stop, second byte then ignored
            do_stop();
            send(hdr(own_addr, 1'b0), 1'b1);
            do_stop();
            send(own_addr[7:0], 1'b0);
            chk("R7 partial cleared by stop", 4'b0000);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule